// File: doc/BRIEF.md
# Dual-Channel Interrupt Status Router

This block keeps the interrupt state of a two-channel disk controller and turns it into one level-sensitive interrupt line. Each channel owns a pending flag and a block (mask) flag. The pending flag of a channel is held twice: once in a channel-specific status byte and once in a shared mode byte. Every path that changes one copy also brings the other copy back into line. Software therefore sees the same pending state at either address.

Channel-side logic reports interrupt activity with a strobe and a level. A strobe with level 1 raises the channel's pending flag, and a strobe with level 0 drops it. Software reads the three status bytes through a combinational read port. It clears pending flags through a byte-addressed write port of up to four bytes per access, with write-one-to-clear semantics. A separate mask write path sets the two block flags. The output is high when at least one channel is pending and not blocked.

Top module: `irq_status_router`

## Requirements
- R1: While reset is asserted and after its release, every pending flag and block flag reads 0 and `irq_o` is 0.
- R2: A `chan_stb[c]` pulse loads `chan_lvl[c]` into channel c's pending flag, visible one cycle later in both copies: channel 0 at byte 0x50 bit 2 and byte 0x71 bit 2, channel 1 at byte 0x57 bit 4 and byte 0x71 bit 3.
- R3: `irq_o` is registered and equals (pending0 and not block0) or (pending1 and not block1) of the state that becomes visible in the same cycle.
- R4: A `mask_wr_en` pulse loads `mask_wr_val[c]` into block flag c, read back at byte 0x71 bit 4 (channel 0) and bit 5 (channel 1).
- R5: A configuration write clears a pending flag when the written byte has 1 at that flag's bit position, and leaves the flag unchanged where it has 0.
- R6: A write that clears a pending copy at 0x50 or 0x57 also clears the copy at 0x71, and a clear at 0x71 also clears the copy at 0x50 or 0x57. The two copies of a flag never differ.
- R7: Configuration writes have no effect on any bit other than the pending bits, and in particular never alter the block flags.
- R8: A configuration write covers `cfg_wr_len` consecutive bytes starting at `cfg_wr_addr` (0 to 4; 0 writes nothing). Byte lane i carries `cfg_wr_data[8i+7:8i]` to address `cfg_wr_addr+i`, and unaligned starts are allowed.
- R9: When a channel strobe and a software clear of that channel occur in the same cycle, the strobe's level decides the resulting pending flag.
- R10: `cfg_rd_data` shows the byte at `cfg_rd_addr` in the same cycle. Unmodelled bits of the three bytes and all other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_stb | input | 2 | Per-channel strobe that applies `chan_lvl` |
| chan_lvl | input | 2 | Per-channel interrupt level, sampled on strobe |
| mask_wr_en | input | 1 | Load enable for the block flags |
| mask_wr_val | input | 2 | New block flags, bit c for channel c |
| cfg_wr_en | input | 1 | Configuration write request |
| cfg_wr_addr | input | 8 | Byte address of write lane 0 |
| cfg_wr_len | input | 3 | Number of bytes written (0 to 4) |
| cfg_wr_data | input | 32 | Write data, lane i in bits 8i+7:8i |
| cfg_rd_addr | input | 8 | Read byte address |
| cfg_rd_data | output | 8 | Read byte, combinational |
| irq_o | output | 1 | Level-sensitive interrupt output |

## Verification
Every stimulus, whether a strobe, a mask write or a configuration write, acts on the next rising edge. The pending copies, the block flags and `irq_o` all change at that edge, so each result is due one cycle after the stimulus. The bench drives inputs on falling edges and samples on the following falling edge, one full cycle later. The read port is combinational, so within that sample point the bench steps `cfg_rd_addr` across the three bytes and compares each after a short settle delay, with no extra edge in between.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int NUM_CH = 2;
  localparam logic [7:0] ADDR_MAIN = 8'h71;

  // byte address holding the channel-specific pending copy
  function automatic logic [7:0] side_addr(input int ch);
    return (ch == 0) ? 8'h50 : 8'h57;
  endfunction

  // bit position of the pending copy inside its channel byte
  function automatic int side_bit(input int ch);
    return (ch == 0) ? 2 : 4;
  endfunction

  // bit position of the pending copy inside the shared mode byte
  function automatic int main_bit(input int ch);
    return 2 + ch;
  endfunction

  // bit position of the block flag inside the shared mode byte
  function automatic int blk_bit(input int ch);
    return 4 + ch;
  endfunction
endpackage

// File: rtl/cfg_write_decode.sv
module cfg_write_decode
  import irq_router_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  localparam int LEN_W = $clog2(LANES + 1)
) (
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [LEN_W-1:0]     wr_len,
  input  logic [8*LANES-1:0]   wr_data,
  output logic [NUM_CH-1:0]    clr_side,
  output logic [NUM_CH-1:0]    clr_main,
  output logic                 sync_to_main,
  output logic                 sync_to_side
);
  logic [LANES-1:0][NUM_CH-1:0] lane_hit_side;
  logic [LANES-1:0][NUM_CH-1:0] lane_clr_side;
  logic [LANES-1:0][NUM_CH-1:0] lane_clr_main;
  logic [LANES-1:0]             lane_hit_main;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [ADDR_W-1:0] l_addr;
    logic              l_on;
    logic [7:0]        l_byte;
    assign l_addr = wr_addr + ADDR_W'(i);
    assign l_on   = wr_en && (wr_len > LEN_W'(i));
    assign l_byte = wr_data[8*i +: 8];
    assign lane_hit_main[i] = l_on && (l_addr == ADDR_W'(ADDR_MAIN));
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam int SB = side_bit(c);
      localparam int MB = main_bit(c);
      assign lane_hit_side[i][c] = l_on && (l_addr == ADDR_W'(side_addr(c)));
      assign lane_clr_side[i][c] = lane_hit_side[i][c] && l_byte[SB];
      assign lane_clr_main[i][c] = lane_hit_main[i] && l_byte[MB];
    end
  end

  always_comb begin
    clr_side     = '0;
    clr_main     = '0;
    sync_to_main = 1'b0;
    sync_to_side = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      clr_side     = clr_side | lane_clr_side[i];
      clr_main     = clr_main | lane_clr_main[i];
      sync_to_main = sync_to_main | (|lane_hit_side[i]);
      sync_to_side = sync_to_side | lane_hit_main[i];
    end
  end
endmodule

// File: rtl/pending_mirror.sv
module pending_mirror (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_active,
  input  logic clr_side,
  input  logic clr_main,
  input  logic sync_to_main,
  input  logic sync_to_side,
  input  logic evt,
  input  logic lvl,
  output logic side_q,
  output logic main_q,
  output logic main_d
);
  logic side_d;
  logic upd_en;
  logic side_cl, main_cl, main_sy, side_sy;

  // clear first, then sync in ascending address order (side bytes sit below
  // the shared byte), then let a channel strobe override
  always_comb begin
    side_cl = side_q & ~clr_side;
    main_cl = main_q & ~clr_main;
    main_sy = sync_to_main ? side_cl : main_cl;
    side_sy = sync_to_side ? main_sy : side_cl;
    main_d  = evt ? lvl : main_sy;
    side_d  = evt ? lvl : side_sy;
    upd_en  = evt | wr_active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      side_q <= 1'b0;
      main_q <= 1'b0;
    end else if (upd_en) begin
      side_q <= side_d;
      main_q <= main_d;
    end
  end
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int NUM_CH = 2
) (
  input  logic [NUM_CH-1:0] pend,
  input  logic [NUM_CH-1:0] blk,
  output logic              level
);
  always_comb level = |(pend & ~blk);
endmodule

// File: rtl/irq_status_router.sv
module irq_status_router
  import irq_router_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  localparam int LEN_W = $clog2(LANES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CH-1:0]    chan_stb,
  input  logic [NUM_CH-1:0]    chan_lvl,
  input  logic                 mask_wr_en,
  input  logic [NUM_CH-1:0]    mask_wr_val,
  input  logic                 cfg_wr_en,
  input  logic [ADDR_W-1:0]    cfg_wr_addr,
  input  logic [LEN_W-1:0]     cfg_wr_len,
  input  logic [8*LANES-1:0]   cfg_wr_data,
  input  logic [ADDR_W-1:0]    cfg_rd_addr,
  output logic [7:0]           cfg_rd_data,
  output logic                 irq_o
);
  logic [NUM_CH-1:0] clr_side, clr_main;
  logic              sync_to_main, sync_to_side;
  logic              wr_active;
  logic [NUM_CH-1:0] side_q, main_q, main_d;
  logic [NUM_CH-1:0] blk_q, blk_d;
  logic              irq_d;

  assign wr_active = cfg_wr_en && (cfg_wr_len != '0);

  cfg_write_decode #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dec (
    .wr_en        (cfg_wr_en),
    .wr_addr      (cfg_wr_addr),
    .wr_len       (cfg_wr_len),
    .wr_data      (cfg_wr_data),
    .clr_side     (clr_side),
    .clr_main     (clr_main),
    .sync_to_main (sync_to_main),
    .sync_to_side (sync_to_side)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_mir
    pending_mirror u_mir (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_active    (wr_active),
      .clr_side     (clr_side[c]),
      .clr_main     (clr_main[c]),
      .sync_to_main (sync_to_main),
      .sync_to_side (sync_to_side),
      .evt          (chan_stb[c]),
      .lvl          (chan_lvl[c]),
      .side_q       (side_q[c]),
      .main_q       (main_q[c]),
      .main_d       (main_d[c])
    );
  end

  always_comb blk_d = mask_wr_en ? mask_wr_val : blk_q;

  irq_combine #(.NUM_CH(NUM_CH)) u_irq (
    .pend  (main_d),
    .blk   (blk_d),
    .level (irq_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= '0;
      irq_o <= 1'b0;
    end else begin
      if (mask_wr_en) blk_q <= blk_d;
      irq_o <= irq_d;
    end
  end

  // read image of the three status bytes
  always_comb begin
    cfg_rd_data = 8'h00;
    for (int c = 0; c < NUM_CH; c++) begin
      if (cfg_rd_addr == ADDR_W'(side_addr(c))) cfg_rd_data[side_bit(c)] = side_q[c];
      if (cfg_rd_addr == ADDR_W'(ADDR_MAIN)) begin
        cfg_rd_data[main_bit(c)] = main_q[c];
        cfg_rd_data[blk_bit(c)]  = blk_q[c];
      end
    end
  end
endmodule

module irq_router_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] chan_stb,
  input logic [1:0] chan_lvl,
  input logic       mask_wr_en,
  input logic [1:0] side_q,
  input logic [1:0] main_q,
  input logic [1:0] blk_q,
  input logic       irq_o
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (irq_o == 1'b0 && main_q == 2'b00 && blk_q == 2'b00));
  // R2
  strobe_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_stb[0] |=> (main_q[0] == $past(chan_lvl[0]) && side_q[0] == $past(chan_lvl[0])));
  // R3
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == |(main_q & ~blk_q));
  // R6
  mirror_sync_chk: assert property (@(posedge clk) disable iff (!rst_n) side_q == main_q);
  // R7
  blk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !mask_wr_en |=> $stable(blk_q));
  // R9
  strobe_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_stb[1] |=> (main_q[1] == $past(chan_lvl[1])));
endmodule

bind irq_status_router irq_router_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .chan_stb   (chan_stb),
  .chan_lvl   (chan_lvl),
  .mask_wr_en (mask_wr_en),
  .side_q     (side_q),
  .main_q     (main_q),
  .blk_q      (blk_q),
  .irq_o      (irq_o)
);

// File: tb/test_irq_status_router.sv
`timescale 1ns/1ps
module test_irq_status_router;
  logic        clk;
  logic        rst_n;
  logic [1:0]  chan_stb, chan_lvl;
  logic        mask_wr_en;
  logic [1:0]  mask_wr_val;
  logic        cfg_wr_en;
  logic [7:0]  cfg_wr_addr;
  logic [2:0]  cfg_wr_len;
  logic [31:0] cfg_wr_data;
  logic [7:0]  cfg_rd_addr;
  logic [7:0]  cfg_rd_data;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [1:0] ep, eb;  // expected pending and block flags

  irq_status_router i_irq_status_router (
    .clk(clk), .rst_n(rst_n), .chan_stb(chan_stb), .chan_lvl(chan_lvl),
    .mask_wr_en(mask_wr_en), .mask_wr_val(mask_wr_val), .cfg_wr_en(cfg_wr_en),
    .cfg_wr_addr(cfg_wr_addr), .cfg_wr_len(cfg_wr_len), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data), .irq_o(irq_o)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  function automatic logic [7:0] img(input logic [7:0] a);
    case (a)
      8'h50:   return {5'b0, ep[0], 2'b0};
      8'h57:   return {3'b0, ep[1], 4'b0};
      8'h71:   return {2'b0, eb, ep, 2'b0};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_chk(input string req, input logic [7:0] a);
    cfg_rd_addr = a;
    #0.2;
    chk(req, cfg_rd_data, img(a));
  endtask

  task automatic check_state(input string req);
    read_chk(req, 8'h50);
    read_chk(req, 8'h57);
    read_chk(req, 8'h71);
    chk({req, " irq"}, {7'b0, irq_o}, {7'b0, |(ep & ~eb)});
  endtask

  task automatic idle();
    chan_stb = 0; chan_lvl = 0; mask_wr_en = 0; mask_wr_val = 0;
    cfg_wr_en = 0; cfg_wr_addr = 0; cfg_wr_len = 0; cfg_wr_data = 0;
  endtask

  // model of one configuration write (lanes ascending)
  task automatic model_write(input logic [7:0] a, input logic [2:0] len, input logic [31:0] d);
    for (int i = 0; i < 4; i++) begin
      logic [7:0] la, b;
      if (i < int'(len)) begin
        la = a + 8'(i);
        b  = d[8*i +: 8];
        if (la == 8'h50 && b[2]) ep[0] = 1'b0;
        if (la == 8'h57 && b[4]) ep[1] = 1'b0;
        if (la == 8'h71 && b[2]) ep[0] = 1'b0;
        if (la == 8'h71 && b[3]) ep[1] = 1'b0;
      end
    end
  endtask

  // drive one cycle of stimulus, then wait until the result is due
  task automatic step(input logic [1:0] stb, input logic [1:0] lvl,
                      input logic men, input logic [1:0] mval,
                      input logic wen, input logic [7:0] a, input logic [2:0] len,
                      input logic [31:0] d);
    chan_stb = stb; chan_lvl = lvl; mask_wr_en = men; mask_wr_val = mval;
    cfg_wr_en = wen; cfg_wr_addr = a; cfg_wr_len = len; cfg_wr_data = d;
    if (wen) model_write(a, len, d);
    for (int c = 0; c < 2; c++) if (stb[c]) ep[c] = lvl[c];
    if (men) eb = mval;
    @(negedge clk);
    idle();
  endtask

  task automatic establish(input logic [1:0] p, input logic [1:0] b);
    step(2'b11, p, 1'b1, b, 1'b0, 8'h00, 3'd0, 32'h0);
  endtask

  initial begin
    idle();
    cfg_rd_addr = 0;
    ep = 0; eb = 0;
    rst_n = 0;
    @(negedge clk);
    @(negedge clk);
    // R1 state while in reset
    check_state("R1");
    rst_n = 1;
    @(negedge clk);
    check_state("R1");

    // R2 R3 R4: every pending/block combination
    for (int p = 0; p < 4; p++) begin
      for (int b = 0; b < 4; b++) begin
        establish(2'(p), 2'(b));
        check_state("R2_R3_R4");
      end
    end

    // R5 R6 R7: single-byte clears at each register, from every state
    for (int p = 0; p < 4; p++) begin
      for (int b = 0; b < 4; b++) begin
        for (int v = 0; v < 16; v++) begin
          establish(2'(p), 2'(b));
          step(2'b00, 2'b00, 1'b0, 2'b00, 1'b1, 8'h71, 3'd1, {24'h0, 2'b0, 4'(v), 2'b0});
          check_state("R5_R6_R7 main");
        end
        establish(2'(p), 2'(b));
        step(2'b00, 2'b00, 1'b0, 2'b00, 1'b1, 8'h50, 3'd1, 32'h04);
        check_state("R6 side0");
        establish(2'(p), 2'(b));
        step(2'b00, 2'b00, 1'b0, 2'b00, 1'b1, 8'h50, 3'd1, 32'hFB);
        check_state("R5 side0 zero");
        establish(2'(p), 2'(b));
        step(2'b00, 2'b00, 1'b0, 2'b00, 1'b1, 8'h57, 3'd1, 32'h10);
        check_state("R6 side1");
        establish(2'(p), 2'(b));
        step(2'b00, 2'b00, 1'b0, 2'b00, 1'b1, 8'h57, 3'd1, 32'hEF);
        check_state("R5 side1 zero");
      end
    end

    // R8: sweep start addresses and lengths, unaligned included
    for (int a = 8'h4C; a <= 8'h74; a++) begin
      for (int len = 0; len <= 4; len++) begin
        establish(2'b11, 2'b00);
        step(2'b00, 2'b00, 1'b0, 2'b00, 1'b1, 8'(a), 3'(len), 32'h1C1C1C1C);
        check_state("R8");
      end
    end
    // R8: lane position matters, only lane 2 carries the clear bits
    establish(2'b11, 2'b00);
    step(2'b00, 2'b00, 1'b0, 2'b00, 1'b1, 8'h6F, 3'd4, 32'h000C0000);
    check_state("R8 lane2");
    establish(2'b11, 2'b00);
    step(2'b00, 2'b00, 1'b0, 2'b00, 1'b1, 8'h6F, 3'd4, 32'h0C000C0C);
    check_state("R8 other lanes");

    // R9: strobe and clear in the same cycle
    for (int l = 0; l < 4; l++) begin
      establish(2'b11, 2'b00);
      step(2'b11, 2'(l), 1'b0, 2'b00, 1'b1, 8'h71, 3'd1, 32'h0C);
      check_state("R9 main");
      establish(2'b11, 2'b00);
      step(2'b01, 2'(l), 1'b0, 2'b00, 1'b1, 8'h50, 3'd1, 32'h04);
      check_state("R9 side");
    end

    // R10: every read address in a fully set state
    establish(2'b11, 2'b11);
    for (int a = 0; a < 256; a++) read_chk("R10", 8'(a));

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule